// File: doc/BRIEF.md
# Manchester Line Transmitter for 10 Mb/s Twisted Pair

This block turns a stream of 4-bit frame nibbles into a two-level Manchester line signal. It runs on a clock at twice the bit rate, so one clock is one half-bit. For 10 Mb/s that clock is 20 MHz. When a frame starts, the block sends the header on its own. The header is 62 alternating bits followed by the two-bit start delimiter. The block then asks the frame source for one nibble at a time and codes each bit. There is no scrambling.

When the source has no more data, the block sends an end marker. The marker is a deliberate coding violation: the line stays high for two whole bit times with no mid-cell edge. After the marker the line falls to the low level and stays flat until the next frame.

The frame source keeps `frame_go` high while it has data to send. It answers each one-cycle `nib_pull` pulse in the same cycle, with the next nibble on `nib_data`, or with `frame_go` low to close the frame.

Top module: `manchester_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `line_q` is 0, `line_busy` is 0 and `nib_pull` is 0, with no transitions on `line_q`.
- R2: `frame_go` high in an idle cycle starts a frame at the next clock edge. From that edge `line_busy` is 1, and the line carries 64 header bit cells. Cells 0 to 61 alternate starting with 1 (1,0,1,0,...). Cells 62 and 63 are both 1.
- R3: Every header and data bit cell lasts two clocks. A 1 is sent as low then high, and a 0 as high then low, so every cell has a transition at its middle.
- R4: `nib_pull` is high for exactly one clock: the second half of header cell 63, and the second half of the fourth bit of every nibble. The block samples `frame_go` and `nib_data` at the clock edge that ends that cycle.
- R5: A nibble sampled with `frame_go` high is sent in the four cells that follow at once, bit 0 first and bit 3 last, with no scrambling.
- R6: If `frame_go` is low when sampled at a pull, the end marker follows. The marker is four clocks of `line_q` high with `line_busy` high. After it, `line_q` and `line_busy` are both 0.
- R7: During a frame, `frame_go` and `nib_data` have no effect except in a `nib_pull` cycle. Pulses in the header, or drops and changes between pulls, leave the line output unchanged.
- R8: A `frame_go` pulse of even one clock during the end marker is held. The next frame starts after exactly one idle clock, even if `frame_go` is low by then.
- R9: If `frame_go` is held high through the end marker, the line still spends exactly one clock idle (both outputs 0) before the next header begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock (20 MHz for 10 Mb/s) |
| rst | input | 1 | Synchronous active-high reset |
| frame_go | input | 1 | Frame request; frame continues while high at each pull |
| nib_data | input | NIB_W | Next nibble, sampled at the end of a `nib_pull` cycle |
| nib_pull | output | 1 | One-cycle request for the next nibble |
| line_q | output | 1 | Manchester line level |
| line_busy | output | 1 | High from the first header half-bit to the last marker half-bit |

## Verification
The bench aims at the frame boundaries. Frames with no data go straight from the start delimiter into the marker; a design that fetched one nibble too many would send an extra cell pattern there instead of a flat high. Requests that arrive during the marker, either as a one-clock pulse at its first or last clock or held high across it, must give exactly one idle clock. A design that dropped the pulse would stay idle, and one that skipped the gap would restart with no idle clock. Random toggling of the inputs between pulls would show up as corrupted data cells if the design sampled at the wrong time. The bench decodes every cell and checks its mid-cell edge, so a swapped polarity or a missing edge is caught cell by cell.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  // Line phase: flat idle, header cells, data cells, end marker
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_SOI  = 2'd3
  } mtx_state_e;

endpackage

// File: rtl/mtx_seq.sv
module mtx_seq
  import mtx_pkg::*;
#(
  parameter int HDR_BITS   = 64,
  parameter int NIB_W      = 4,
  parameter int SOI_HALVES = 4,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  output mtx_state_e       st_q,
  output mtx_state_e       nxt_st,
  output logic [CNT_W-1:0] idx_q,
  output logic [CNT_W-1:0] nxt_idx,
  output logic             half_q,
  output logic             nxt_half,
  output logic             load_o,
  output logic             req_q
);

  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] NIB_LAST = CNT_W'(NIB_W - 1);
  localparam logic [CNT_W-1:0] SOI_LAST = CNT_W'(SOI_HALVES - 1);

  logic pend_q, nxt_pend;
  logic at_fetch, nxt_fetch;

  function automatic logic fetch_pt(mtx_state_e s, logic [CNT_W-1:0] i, logic h);
    return h && ((s == ST_HDR && i == HDR_LAST) || (s == ST_DATA && i == NIB_LAST));
  endfunction

  assign at_fetch  = fetch_pt(st_q, idx_q, half_q);
  assign nxt_fetch = fetch_pt(nxt_st, nxt_idx, nxt_half);

  always_comb begin
    nxt_st   = st_q;
    nxt_idx  = idx_q;
    nxt_half = half_q;
    nxt_pend = pend_q;
    load_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go_i || pend_q) begin
          nxt_st   = ST_HDR;
          nxt_idx  = '0;
          nxt_half = 1'b0;
          nxt_pend = 1'b0;
        end
      end
      ST_HDR, ST_DATA: begin
        if (!half_q) begin
          nxt_half = 1'b1;
        end else if (at_fetch) begin
          nxt_half = 1'b0;
          nxt_idx  = '0;
          if (go_i) begin
            nxt_st = ST_DATA;
            load_o = 1'b1;
          end else begin
            nxt_st = ST_SOI;
          end
        end else begin
          nxt_half = 1'b0;
          nxt_idx  = idx_q + 1'b1;
        end
      end
      ST_SOI: begin
        nxt_pend = pend_q | go_i;
        nxt_half = 1'b0;
        if (idx_q == SOI_LAST) begin
          nxt_st  = ST_IDLE;
          nxt_idx = '0;
        end else begin
          nxt_idx = idx_q + 1'b1;
        end
      end
      default: nxt_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      half_q <= 1'b0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      st_q   <= nxt_st;
      idx_q  <= nxt_idx;
      half_q <= nxt_half;
      pend_q <= nxt_pend;
      req_q  <= nxt_fetch;
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q); // R4

  AST_REQ_AT_CELL_END: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (half_q && (st_q == ST_HDR || st_q == ST_DATA))); // R4

  AST_SOI_EXIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SOI && idx_q == SOI_LAST) |=> (st_q == ST_IDLE)); // R6

  AST_HELD_START: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && pend_q) |=> (st_q == ST_HDR)); // R8

endmodule

// File: rtl/mtx_nib.sv
module mtx_nib #(
  parameter int NIB_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             bit_o
);

  logic [NIB_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (load_i) begin
      hold_q <= nib_i;
    end
  end

  // Bypass so bit 0 of a freshly pulled nibble goes out at the load edge
  assign bit_o = load_i ? nib_i[sel_i] : hold_q[sel_i];

endmodule

// File: rtl/mtx_line.sv
module mtx_line
  import mtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  mtx_state_e nxt_st,
  input  logic       nxt_half,
  input  logic       nxt_bit,
  output logic       line_q,
  output logic       busy_q
);

  logic lvl;

  always_comb begin
    unique case (nxt_st)
      ST_IDLE:         lvl = 1'b0;
      ST_SOI:          lvl = 1'b1;
      ST_HDR, ST_DATA: lvl = nxt_half ? nxt_bit : ~nxt_bit;
      default:         lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      line_q <= lvl;
      busy_q <= (nxt_st != ST_IDLE);
    end
  end

endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mtx_pkg::*;
#(
  parameter int PRE_BITS   = 62,
  parameter int SFD_BITS   = 2,
  parameter int SOI_BITS   = 2,
  parameter int NIB_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_go,
  input  logic [NIB_W-1:0] nib_data,
  output logic             nib_pull,
  output logic             line_q,
  output logic             line_busy
);

  localparam int HDR_BITS   = PRE_BITS + SFD_BITS;
  localparam int SOI_HALVES = 2 * SOI_BITS;
  localparam int CNT_W      = $clog2(HDR_BITS + 1);
  localparam int SEL_W      = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_BITS);

  mtx_state_e       st_q, nxt_st;
  logic [CNT_W-1:0] idx_q, nxt_idx;
  logic             half_q, nxt_half, load;
  logic             hdr_bit, dat_bit, cell_bit;

  mtx_seq #(
    .HDR_BITS  (HDR_BITS),
    .NIB_W     (NIB_W),
    .SOI_HALVES(SOI_HALVES),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .go_i    (frame_go),
    .st_q    (st_q),
    .nxt_st  (nxt_st),
    .idx_q   (idx_q),
    .nxt_idx (nxt_idx),
    .half_q  (half_q),
    .nxt_half(nxt_half),
    .load_o  (load),
    .req_q   (nib_pull)
  );

  mtx_nib #(
    .NIB_W(NIB_W),
    .SEL_W(SEL_W)
  ) u_nib (
    .clk   (clk),
    .rst   (rst),
    .load_i(load),
    .nib_i (nib_data),
    .sel_i (nxt_idx[SEL_W-1:0]),
    .bit_o (dat_bit)
  );

  // Header: alternating from 1 up to PRE_BITS, then all ones for the delimiter
  assign hdr_bit  = (nxt_idx < PRE_END) ? ~nxt_idx[0] : 1'b1;
  assign cell_bit = (nxt_st == ST_HDR) ? hdr_bit : dat_bit;

  mtx_line u_line (
    .clk     (clk),
    .rst     (rst),
    .nxt_st  (nxt_st),
    .nxt_half(nxt_half),
    .nxt_bit (cell_bit),
    .line_q  (line_q),
    .busy_q  (line_busy)
  );

  AST_IDLE_FLAT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (!line_q && !line_busy)); // R1

  AST_START_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(line_busy) |-> (st_q == ST_HDR && idx_q == '0 && !half_q)); // R2

  AST_MID_EDGE: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_HDR || st_q == ST_DATA) && half_q) |-> (line_q != $past(line_q))); // R3

  AST_SOI_FLAT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SOI) |-> (line_q && line_busy)); // R6

  AST_LOAD_AT_PULL: assert property (@(posedge clk) disable iff (rst)
    load |-> nib_pull); // R7

endmodule

// File: tb/manchester_tx_bench.sv
module manchester_tx_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       frame_go;
  logic [3:0] nib_data;
  logic       nib_pull;
  logic       line_q;
  logic       line_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  manchester_tx u_manchester_tx (
    .clk      (clk),
    .rst      (rst),
    .frame_go (frame_go),
    .nib_data (nib_data),
    .nib_pull (nib_pull),
    .line_q   (line_q),
    .line_busy(line_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_checks(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk(line_q === 1'b0, "R1 idle line", int'(line_q), 0);
      chk(line_busy === 1'b0, "R1 idle busy", int'(line_busy), 0);
      chk(nib_pull === 1'b0, "R1 idle pull", int'(nib_pull), 0);
      nib_data = 4'($urandom);
    end
  endtask

  // Start edge must be the next posedge. mode: 0 plain end, 1 pulse in marker, 2 hold from pos
  task automatic run_frame(input int n, input int mode, input int pos);
    logic [3:0] nib [16];
    logic prev;
    int total;
    for (int j = 0; j < n; j++) nib[j] = 4'($urandom);
    total = 2 * 64 + 8 * n;
    prev  = 1'b0;
    for (int k = 0; k < total; k++) begin
      int b;
      logic eb, eh, fetch;
      @(negedge clk);
      b = k / 2;
      if (b < 64) eb = (b < 62) ? ((b % 2) == 0) : 1'b1;
      else        eb = nib[(b - 64) / 4][(b - 64) % 4];
      eh = (k % 2) ? eb : ~eb;
      if (b < 64) chk(line_q === eh, "R2 header half", int'(line_q), int'(eh));
      else        chk(line_q === eh, "R5 R7 data half", int'(line_q), int'(eh));
      chk(line_busy === 1'b1, "R2 busy in frame", int'(line_busy), 1);
      if (k % 2) chk(line_q !== prev, "R3 mid-cell transition", int'(line_q), int'(~prev));
      fetch = (k >= 127) && (((k - 127) % 8) == 0);
      chk(nib_pull === fetch, "R4 pull timing", int'(nib_pull), int'(fetch));
      if (fetch) begin
        int j;
        j = (k - 127) / 8;
        if (j < n) begin
          frame_go = 1'b1;
          nib_data = nib[j];
        end else begin
          frame_go = 1'b0;
          nib_data = 4'($urandom);
        end
      end else begin
        frame_go = 1'($urandom);
        nib_data = 4'($urandom);
      end
      prev = line_q;
    end
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      chk(line_q === 1'b1, "R6 marker high", int'(line_q), 1);
      chk(line_busy === 1'b1, "R6 marker busy", int'(line_busy), 1);
      chk(nib_pull === 1'b0, "R4 no pull in marker", int'(nib_pull), 0);
      if (mode == 1)      frame_go = (s == pos);
      else if (mode == 2) frame_go = (s >= pos);
      else                frame_go = 1'b0;
    end
    @(negedge clk);
    if (mode == 1) begin
      chk(line_q === 1'b0 && line_busy === 1'b0, "R8 one idle clock", int'(line_busy), 0);
      frame_go = 1'b0;
    end else if (mode == 2) begin
      chk(line_q === 1'b0 && line_busy === 1'b0, "R9 one idle clock", int'(line_busy), 0);
    end else begin
      chk(line_q === 1'b0, "R6 release line", int'(line_q), 0);
      chk(line_busy === 1'b0, "R6 release busy", int'(line_busy), 0);
      idle_checks(5);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst      = 1'b1;
    frame_go = 1'b0;
    nib_data = 4'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle_checks(6);

    // Directed: empty frame, then marker pulses at both ends, then held request
    frame_go = 1'b1;
    run_frame(0, 0, 0);
    frame_go = 1'b1;
    run_frame(1, 1, 0);
    run_frame(2, 1, 3);
    run_frame(3, 2, 1);
    run_frame(1, 0, 0);

    for (int f = 0; f < 12; f++) begin
      frame_go = 1'b1;
      run_frame(int'($urandom % 9), 0, 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule